// File: doc/BRIEF.md
# Front-End Configuration Word Serializer

This block sends one configuration word to a readout front end over a single data wire. The word is 39 bits long. It is built from a start marker, a soft-reset request, a mode selector, a hold-time count and four window bounds. The word is shifted out most significant bit first, and each bit stays on the wire for a fixed number of clocks. The line sits low whenever no word is being sent.

Transfers are tied to the frame synchronisation input `fsync_i`. A frame begins on a falling edge of `fsync_i`. A transfer may only start while `fsync_i` is high, and it must finish, including a trailing guard time, before `fsync_i` falls again. If a request arrives while `fsync_i` is low, the block holds it and starts on the next rising edge. If `fsync_i` falls before the transfer and guard are over, the block aborts and raises a sticky violation flag.

The controller has four states:
- `ST_IDLE`: waiting for a request.
- `ST_ARMED`: a request has been accepted while `fsync_i` is low, and the block waits for the rising edge.
- `ST_SEND`: bits are being shifted out.
- `ST_GUARD`: the trailing 10-clock margin.

The transitions are:
- IDLE→SEND: request accepted with `fsync_i` high.
- IDLE→ARMED: request accepted with `fsync_i` low.
- ARMED→SEND: rising edge seen.
- SEND→GUARD: the last clock of the last bit.
- GUARD→IDLE: end of the margin.
- SEND/GUARD→IDLE: abort on a falling edge.

Top module: `cfgword_serializer`

## Requirements
- R1: After reset, `sdata_o`, `busy_o` and `viol_o` are all 0.
- R2: Word bit positions, with bit 38 sent first:
  - bit 38: start marker
  - bit 37: soft reset
  - bits 36:31: mode
  - bits 30:24: hold count
  - bits 23:18: row window start
  - bits 17:12: row window end
  - bits 11:6: column window start
  - bits 5:0: column window end
- R3: Each bit is driven for exactly 8 consecutive clocks.
- R4: A request accepted in `ST_IDLE` with `fsync_i` high starts the transfer immediately. Bit 38 appears in the cycle after the accepting edge.
- R5: A request made while `fsync_i` is low is deferred. `busy_o` is 1 and the line stays low until a rising edge of `fsync_i` is sampled. Bit 38 appears in the cycle after that edge.
- R6: `busy_o` stays 1 for 39×8+10 = 322 cycles after transmission starts. The line is low for the last 10 of them and whenever the block is idle.
- R7: If `fsync_i` falls during `ST_SEND` or `ST_GUARD`, the transfer is abandoned at that edge: `busy_o` and `sdata_o` go to 0 and `viol_o` goes to 1. A falling edge of `fsync_i` while idle does not set `viol_o`.
- R8: `viol_o` stays 1 until the next request is accepted. It is 0 in the cycle after the accepting edge.
- R9: The fields are captured at the accepting edge. While `busy_o` is 1, further requests and field changes have no effect on the bits sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | active-low asynchronous reset |
| start_flag_i | input | 1 | start marker field |
| soft_rst_i | input | 1 | soft-reset field |
| mode_i | input | 6 | operating mode field |
| hold_i | input | 7 | hold count field (front end multiplies by four) |
| row_beg_i | input | 6 | row window start |
| row_end_i | input | 6 | row window end |
| col_beg_i | input | 6 | column window start |
| col_end_i | input | 6 | column window end |
| send_req_i | input | 1 | transfer request, sampled when idle |
| fsync_i | input | 1 | frame synchronisation |
| sdata_o | output | 1 | serial data line |
| busy_o | output | 1 | request pending or transfer/guard in progress |
| viol_o | output | 1 | sticky timing-violation flag |

## Verification
Three word patterns are sent while `fsync_i` is high: a single 1 walked across all 39 positions, all zeros, and all ones. The walking-one pattern tells apart every misplaced field or bit-order error. The all-zeros and all-ones words catch stuck lines and inverted output. Every clock of every bit and of the guard window is sampled, so the 8-clock hold and the 322-cycle busy span are checked exactly.

During each of these transfers the request is held high and the fields are inverted. This separates latched fields from live ones. Separate runs cover three more cases:
- a request deferred across a low `fsync_i`;
- a falling edge in the data phase and a falling edge in the guard phase, which must flag a violation;
- a falling edge after completion, which must not.

// File: rtl/cfgword_pkg.sv
package cfgword_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_SEND  = 2'd2,
        ST_GUARD = 2'd3
    } ser_state_e;
endpackage

// File: rtl/cfgword_edge.sv
module cfgword_edge (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic sig_i,
    output logic rise_o,
    output logic fall_o
);
    logic sig_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sig_q <= 1'b0;
        else         sig_q <= sig_i;
    end

    assign rise_o = sig_i & ~sig_q;
    assign fall_o = ~sig_i & sig_q;
endmodule

// File: rtl/cfgword_pack.sv
module cfgword_pack #(
    parameter int MODE_W = 6,
    parameter int HOLD_W = 7,
    parameter int WIN_W  = 6,
    localparam int WORD_W = 2 + MODE_W + HOLD_W + 4 * WIN_W
) (
    input  logic              start_flag_i,
    input  logic              soft_rst_i,
    input  logic [MODE_W-1:0] mode_i,
    input  logic [HOLD_W-1:0] hold_i,
    input  logic [WIN_W-1:0]  row_beg_i,
    input  logic [WIN_W-1:0]  row_end_i,
    input  logic [WIN_W-1:0]  col_beg_i,
    input  logic [WIN_W-1:0]  col_end_i,
    output logic [WORD_W-1:0] word_o
);
    // field order is what the receiver decodes, top bit first
    assign word_o = {start_flag_i, soft_rst_i, mode_i, hold_i,
                     row_beg_i, row_end_i, col_beg_i, col_end_i};
endmodule

// File: rtl/cfgword_shifter.sv
module cfgword_shifter #(
    parameter int WORD_W   = 39,
    parameter int BIT_CLKS = 8,
    localparam int HCW = (BIT_CLKS > 1) ? $clog2(BIT_CLKS) : 1,
    localparam int BCW = $clog2(WORD_W)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              load_i,
    input  logic              run_i,
    input  logic [WORD_W-1:0] word_i,
    output logic              msb_o,
    output logic              last_o
);
    logic [WORD_W-1:0] shreg_q;
    logic [HCW-1:0]    hold_q;
    logic [BCW-1:0]    bit_q;
    logic              bit_end;

    assign bit_end = (hold_q == HCW'(BIT_CLKS - 1));
    assign last_o  = run_i && bit_end && (bit_q == BCW'(WORD_W - 1));
    assign msb_o   = shreg_q[WORD_W-1];

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            shreg_q <= '0;
            hold_q  <= '0;
            bit_q   <= '0;
        end else if (load_i) begin
            shreg_q <= word_i;
            hold_q  <= '0;
            bit_q   <= '0;
        end else if (run_i) begin
            if (bit_end) begin
                shreg_q <= {shreg_q[WORD_W-2:0], 1'b0};
                hold_q  <= '0;
                bit_q   <= bit_q + 1'b1;
            end else begin
                hold_q  <= hold_q + 1'b1;
            end
        end
    end

    AST_BIT_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run_i && $past(run_i) && !$past(load_i) && $past(hold_q) != HCW'(BIT_CLKS - 1))
            |-> $stable(msb_o)) else $error("bit changed inside hold"); // R3

    AST_BIT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        run_i |-> (bit_q < BCW'(WORD_W))) else $error("bit index overrun"); // R6
endmodule

// File: rtl/cfgword_serializer.sv
module cfgword_serializer
    import cfgword_pkg::*;
#(
    parameter int MODE_W     = 6,
    parameter int HOLD_W     = 7,
    parameter int WIN_W      = 6,
    parameter int BIT_CLKS   = 8,
    parameter int GUARD_CLKS = 10
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              start_flag_i,
    input  logic              soft_rst_i,
    input  logic [MODE_W-1:0] mode_i,
    input  logic [HOLD_W-1:0] hold_i,
    input  logic [WIN_W-1:0]  row_beg_i,
    input  logic [WIN_W-1:0]  row_end_i,
    input  logic [WIN_W-1:0]  col_beg_i,
    input  logic [WIN_W-1:0]  col_end_i,
    input  logic              send_req_i,
    input  logic              fsync_i,
    output logic              sdata_o,
    output logic              busy_o,
    output logic              viol_o
);
    localparam int WORD_W = 2 + MODE_W + HOLD_W + 4 * WIN_W;
    localparam int GCW    = (GUARD_CLKS > 1) ? $clog2(GUARD_CLKS) : 1;

    ser_state_e        state_q, state_d;
    logic [WORD_W-1:0] word;
    logic              fs_rise, fs_fall;
    logic              load, run, msb, last;
    logic [GCW-1:0]    guard_q;
    logic              guard_end;
    logic              abort;

    cfgword_edge i_edge (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .sig_i  (fsync_i),
        .rise_o (fs_rise),
        .fall_o (fs_fall)
    );

    cfgword_pack #(.MODE_W(MODE_W), .HOLD_W(HOLD_W), .WIN_W(WIN_W)) i_pack (
        .start_flag_i (start_flag_i),
        .soft_rst_i   (soft_rst_i),
        .mode_i       (mode_i),
        .hold_i       (hold_i),
        .row_beg_i    (row_beg_i),
        .row_end_i    (row_end_i),
        .col_beg_i    (col_beg_i),
        .col_end_i    (col_end_i),
        .word_o       (word)
    );

    cfgword_shifter #(.WORD_W(WORD_W), .BIT_CLKS(BIT_CLKS)) i_shift (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .load_i (load),
        .run_i  (run),
        .word_i (word),
        .msb_o  (msb),
        .last_o (last)
    );

    assign guard_end = (guard_q == GCW'(GUARD_CLKS - 1));
    assign abort     = ((state_q == ST_SEND) || (state_q == ST_GUARD)) && fs_fall;

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (send_req_i) state_d = fsync_i ? ST_SEND : ST_ARMED;
            ST_ARMED: if (fs_rise)    state_d = ST_SEND;
            ST_SEND:  if (fs_fall)    state_d = ST_IDLE;
                      else if (last)  state_d = ST_GUARD;
            ST_GUARD: if (fs_fall || guard_end) state_d = ST_IDLE;
            default:                  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= ST_IDLE;
        else         state_q <= state_d;
    end

    // outputs and datapath controls
    always_comb begin
        load    = 1'b0;
        run     = 1'b0;
        busy_o  = 1'b1;
        sdata_o = 1'b0;
        unique case (state_q)
            ST_IDLE:  begin busy_o = 1'b0; load = send_req_i; end
            ST_ARMED: ;
            ST_SEND:  begin run = 1'b1; sdata_o = msb; end
            ST_GUARD: ;
            default:  busy_o = 1'b0;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                   guard_q <= '0;
        else if (state_q != ST_GUARD)  guard_q <= '0;
        else if (!guard_end)           guard_q <= guard_q + 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                                  viol_o <= 1'b0;
        else if (abort)                               viol_o <= 1'b1;
        else if ((state_q == ST_IDLE) && send_req_i)  viol_o <= 1'b0;
    end

    AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !busy_o |-> !sdata_o) else $error("line active while idle"); // R6

    AST_START_IN_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_SEND && $past(state_q) != ST_SEND) |-> $past(fsync_i))
        else $error("transfer began with fsync low"); // R4

    AST_FALL_ABORTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((state_q == ST_SEND || state_q == ST_GUARD) && !fsync_i && $past(fsync_i))
            |=> (!busy_o && viol_o)) else $error("fall not flagged"); // R7

    AST_VIOL_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (viol_o && state_q == ST_IDLE && !send_req_i) |=> viol_o)
        else $error("violation flag lost"); // R8
endmodule

// File: tb/test_cfgword_serializer.sv
module test_cfgword_serializer;
    localparam int CLK_PERIOD = 10;
    localparam int WORD_W     = 39;
    localparam int BIT_CLKS   = 8;
    localparam int GUARD_CLKS = 10;
    localparam int SPAN       = WORD_W * BIT_CLKS;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       st = 1'b0, sr = 1'b0;
    logic [5:0] mode = '0;
    logic [6:0] hold = '0;
    logic [5:0] rb = '0, re = '0, cb = '0, ce = '0;
    logic       send_req = 1'b0;
    logic       fsync = 1'b1;
    logic       sdata, busy, viol;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    cfgword_serializer i_cfgword_serializer (
        .clk_i (clk), .rst_ni (rst_n),
        .start_flag_i (st), .soft_rst_i (sr), .mode_i (mode), .hold_i (hold),
        .row_beg_i (rb), .row_end_i (re), .col_beg_i (cb), .col_end_i (ce),
        .send_req_i (send_req), .fsync_i (fsync),
        .sdata_o (sdata), .busy_o (busy), .viol_o (viol)
    );

    task automatic check(string req, longint act, longint exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk); #2;
    endtask

    // R2 layout: 38 start, 37 soft reset, 36:31 mode, 30:24 hold, 23:18/17:12 rows, 11:6/5:0 cols
    task automatic apply(logic [38:0] w);
        {st, sr, mode, hold, rb, re, cb, ce} = w;
    endtask

    // called right after the edge that starts shifting
    task automatic check_stream(logic [38:0] w);
        for (int b = WORD_W - 1; b >= 0; b--) begin
            for (int h = 0; h < BIT_CLKS; h++) begin
                @(negedge clk);
                check("R2 R3 serial bit", sdata, w[b]);
                check("R6 busy in data", busy, 1);
                tick();
            end
        end
        for (int g = 0; g < GUARD_CLKS; g++) begin
            @(negedge clk);
            check("R6 guard line low", sdata, 0);
            check("R6 guard busy", busy, 1);
            tick();
        end
        send_req = 1'b0;
        @(negedge clk);
        check("R6 idle after span", busy, 0);
        check("R6 idle line low", sdata, 0);
        tick();
    endtask

    task automatic full_send(logic [38:0] w);
        apply(w);
        send_req = 1'b1;
        tick();
        apply(~w);       // R9 field changes and held request ignored
        check_stream(w);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #3;
        check("R1 reset sdata", sdata, 0);
        check("R1 reset busy", busy, 0);
        check("R1 reset viol", viol, 0);
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        @(negedge clk);
        check("R1 after release busy", busy, 0);
        tick();

        // R2 R4 walking one over every bit position
        for (int p = 0; p < WORD_W; p++) full_send(39'd1 << p);
        full_send('0);
        full_send('1);
        full_send(39'h5A_C3F0_9E21);

        // R5 deferred request
        fsync = 1'b0;
        apply(39'h4B_1D2E_8C35);
        send_req = 1'b1;
        tick();
        send_req = 1'b0;
        apply('0);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            check("R5 pending busy", busy, 1);
            check("R5 pending line low", sdata, 0);
            tick();
        end
        fsync = 1'b1;
        tick();
        check_stream(39'h4B_1D2E_8C35);

        // R7 fall during data phase
        apply('1);
        send_req = 1'b1;
        tick();
        send_req = 1'b0;
        repeat (50) tick();
        fsync = 1'b0;
        tick();
        @(negedge clk);
        check("R7 abort viol", viol, 1);
        check("R7 abort busy", busy, 0);
        check("R7 abort line", sdata, 0);
        tick();
        repeat (20) tick();
        @(negedge clk);
        check("R8 viol held", viol, 1);
        fsync = 1'b1;
        tick();
        @(negedge clk);
        check("R8 viol held over rise", viol, 1);
        send_req = 1'b1;
        tick();
        send_req = 1'b0;
        @(negedge clk);
        check("R8 viol cleared", viol, 0);
        check("R8 busy after accept", busy, 1);
        repeat (SPAN + GUARD_CLKS) tick();
        @(negedge clk);
        check("R6 done", busy, 0);

        // R7 fall during guard
        send_req = 1'b1;
        tick();
        send_req = 1'b0;
        repeat (SPAN + 4) tick();
        @(negedge clk);
        check("R6 in guard", busy, 1);
        fsync = 1'b0;
        tick();
        @(negedge clk);
        check("R7 guard abort viol", viol, 1);
        check("R7 guard abort busy", busy, 0);
        fsync = 1'b1;
        tick();

        // R7 fall when idle sets nothing
        full_send(39'h12_3456_789A);
        @(negedge clk);
        check("R8 viol cleared by send", viol, 0);
        fsync = 1'b0;
        tick();
        tick();
        @(negedge clk);
        check("R7 idle fall no viol", viol, 0);
        check("R7 idle fall busy", busy, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule